// File: doc/BRIEF.md
# Multi-Lane Audio Transmit Sample Buffer

This block is the transmit data path of a serial audio port that drives up to eight data lines in parallel. Every line owns a private sample queue. A simple register write bus loads 32-bit samples, either through a data address per line or, in combined mode, through one common address. In combined mode the block spreads successive words over the enabled lines itself.

On each slot strobe, every enabled line pops one word at the same moment and presents it to its serializer. A line whose queue is empty at that strobe reports an underrun. The block also shows per-line fill levels and overflow flags. It raises a refill request when all enabled lines have drained to a programmable watermark or below. Which lines are enabled is set by an arbitrary, possibly non-contiguous mask.

Top module: `txl_bank`

## Requirements
- R1: After reset the lane mask is 0x01 (only line 0 enabled), the mode is per-line, the watermark is 0, all fill levels, flags and output words are 0, and `fifo_req` is 0.
- R2: A write to address 0x08+i (i in 0..7) in per-line mode appends `wr_data` to line i's queue only. `lane_level` for that line rises by one, and words leave in the order written.
- R3: On a cycle with `slot_stb` and `tx_en` both high, every enabled line with data pops one word, which appears on its `lane_word` slice after that clock edge. Disabled lines do not pop and show 0.
- R4: An enabled line that is empty at such a strobe outputs 0 for that slot and sets its bit in `urun_flags`. A disabled line never sets its underrun bit.
- R5: Flags are sticky. Writing address 0x01 clears underrun bit i when `wr_data[i]` is 1 and overflow bit i when `wr_data[8+i]` is 1. Zero bits leave the flags unchanged.
- R6: A write to a full queue (level equal to DEPTH) is dropped, the level stays at DEPTH, and that line's `ovf_flags` bit is set.
- R7: Address 0x00 holds the control fields: lane mask in `wr_data[7:0]`, mode in `wr_data[9:8]` (value 2 selects combined mode) and watermark in `wr_data[16 +: LVL_W]`. In combined mode, writes to address 0x02 go to the enabled lines in ascending order and wrap back to the lowest enabled line.
- R8: In combined mode, per-line data addresses are ignored. In per-line mode, the common address 0x02 is ignored.
- R9: `fifo_req` is high exactly when `tx_en` is high and every enabled line's level is at or below the watermark.
- R10: Mask and mode writes take effect only while `tx_en` is low. While it is high they are ignored, but the watermark still updates.
- R11: A falling edge of `tx_en` empties all queues and returns the combined-mode write position to line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable |
| slot_stb | input | 1 | Frame-slot strobe, one pop per enabled line |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 32 | Register write data |
| lane_word | output | NUM_LANES*32 | Per-line output word, line i at [i*32 +: 32] |
| lane_level | output | NUM_LANES*LVL_W | Per-line fill level |
| urun_flags | output | NUM_LANES | Sticky underrun flags |
| ovf_flags | output | NUM_LANES | Sticky overflow flags |
| fifo_req | output | 1 | Refill request |

## Verification
The bench targets a non-contiguous mask (0xA5 and then 0x26). A design that assumed consecutive lines would pop, underrun or steer words onto the wrong lines. It also checks an empty enabled line at a strobe, where a faulty design would replay a stale word or blame a disabled line. It writes one word past a full queue, where a faulty design would wrap and corrupt data. It tries a mask write while the transmitter runs, which a faulty design would apply mid-stream. Finally it checks that the combined-mode write position returns to the lowest line after a disable, which a design that skips this would get wrong.

// File: rtl/txl_pkg.sv
package txl_pkg;

    localparam int MAX_LANES  = 8;
    localparam int LANE_IDX_W = 3;
    localparam int ADDR_W     = 6;

    localparam logic [ADDR_W-1:0] ADDR_CTRL    = 6'h00;
    localparam logic [ADDR_W-1:0] ADDR_FLAGCLR = 6'h01;
    localparam logic [ADDR_W-1:0] ADDR_COMMON  = 6'h02;
    localparam logic [2:0]        LANE_PAGE    = 3'b001;

    typedef enum logic [1:0] {
        MODE_SPLIT    = 2'd0,
        MODE_RSVD1    = 2'd1,
        MODE_COMBINED = 2'd2,
        MODE_RSVD3    = 2'd3
    } tx_mode_e;

    typedef struct packed {
        logic                  valid;
        logic [LANE_IDX_W-1:0] idx;
    } lane_pick_t;

    // First enabled lane at or after 'start', wrapping around.
    function automatic lane_pick_t pick_lane(input logic [MAX_LANES-1:0] mask,
                                             input logic [LANE_IDX_W-1:0] start);
        lane_pick_t p;
        p = '0;
        for (int k = MAX_LANES - 1; k >= 0; k--) begin
            logic [LANE_IDX_W-1:0] cand;
            cand = start + LANE_IDX_W'(k);
            if (mask[cand]) begin
                p.valid = 1'b1;
                p.idx   = cand;
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/txl_lane_fifo.sv
module txl_lane_fifo #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic [LVL_W-1:0]  level,
    output logic              full,
    output logic              empty
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     rd_ptr, wr_ptr;
    logic [LVL_W-1:0]  count;
    logic              do_push, do_pop;

    assign full    = (count == LVL_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rd_ptr];
    assign level   = count;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/txl_steer.sv
module txl_steer
    import txl_pkg::*;
#(
    parameter int NUM_LANES = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  flush,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic                  combined,
    input  logic [MAX_LANES-1:0]  mask,
    output logic [NUM_LANES-1:0]  lane_push
);
    logic [LANE_IDX_W-1:0] ptr_q;
    lane_pick_t            pick;
    logic                  common_hit, lane_hit;
    logic [LANE_IDX_W-1:0] lane_sel;

    assign pick       = pick_lane(mask, ptr_q);
    assign common_hit = wr_en && (wr_addr == ADDR_COMMON);
    assign lane_hit   = wr_en && (wr_addr[ADDR_W-1:LANE_IDX_W] == LANE_PAGE);
    assign lane_sel   = wr_addr[LANE_IDX_W-1:0];

    always_comb begin
        for (int i = 0; i < NUM_LANES; i++) begin
            if (combined)
                lane_push[i] = common_hit && pick.valid && (pick.idx == LANE_IDX_W'(i));
            else
                lane_push[i] = lane_hit && (lane_sel == LANE_IDX_W'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush)
            ptr_q <= '0;
        else if (combined && common_hit && pick.valid)
            ptr_q <= pick.idx + 1'b1;
    end
endmodule

// File: rtl/txl_bank.sv
module txl_bank
    import txl_pkg::*;
#(
    parameter int NUM_LANES = 8,
    parameter int DEPTH     = 16,
    parameter int DATA_W    = 32,
    localparam int LVL_W    = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        tx_en,
    input  logic                        slot_stb,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    output logic [NUM_LANES*DATA_W-1:0] lane_word,
    output logic [NUM_LANES*LVL_W-1:0]  lane_level,
    output logic [NUM_LANES-1:0]        urun_flags,
    output logic [NUM_LANES-1:0]        ovf_flags,
    output logic                        fifo_req
);
    localparam logic [MAX_LANES-1:0] LANE_EXIST = MAX_LANES'((1 << NUM_LANES) - 1);

    logic [MAX_LANES-1:0] mask_q, mask_eff;
    tx_mode_e             mode_q;
    logic [LVL_W-1:0]     wm_q;
    logic                 tx_en_q, flush;
    logic                 ctrl_wr, clr_wr;

    logic [NUM_LANES-1:0] push, pop_req, empty, full;
    logic [NUM_LANES-1:0] urun_evt, ovf_evt;
    logic [DATA_W-1:0]    fifo_dout [NUM_LANES];
    logic [LVL_W-1:0]     fifo_lvl  [NUM_LANES];
    logic                 all_low;

    assign mask_eff = mask_q & LANE_EXIST;
    assign flush    = tx_en_q && !tx_en;
    assign ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
    assign clr_wr   = wr_en && (wr_addr == ADDR_FLAGCLR);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= MAX_LANES'(1);
            mode_q  <= MODE_SPLIT;
            wm_q    <= '0;
            tx_en_q <= 1'b0;
        end else begin
            tx_en_q <= tx_en;
            if (ctrl_wr) begin
                wm_q <= wr_data[16 +: LVL_W];
                if (!tx_en) begin
                    mask_q <= wr_data[MAX_LANES-1:0];
                    mode_q <= tx_mode_e'(wr_data[9:8]);
                end
            end
        end
    end

    txl_steer #(.NUM_LANES(NUM_LANES)) u_steer (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .combined (mode_q == MODE_COMBINED),
        .mask     (mask_eff),
        .lane_push(push)
    );

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        assign pop_req[i]  = slot_stb && tx_en && mask_eff[i];
        assign urun_evt[i] = pop_req[i] && empty[i];
        assign ovf_evt[i]  = push[i] && full[i];

        txl_lane_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
            .clk  (clk),
            .rst  (rst),
            .flush(flush),
            .push (push[i]),
            .din  (wr_data),
            .pop  (pop_req[i]),
            .dout (fifo_dout[i]),
            .level(fifo_lvl[i]),
            .full (full[i]),
            .empty(empty[i])
        );

        always_ff @(posedge clk) begin
            if (rst)
                lane_word[i*DATA_W +: DATA_W] <= '0;
            else if (slot_stb && tx_en)
                lane_word[i*DATA_W +: DATA_W] <= (pop_req[i] && !empty[i]) ? fifo_dout[i] : '0;
        end

        assign lane_level[i*LVL_W +: LVL_W] = fifo_lvl[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            urun_flags <= '0;
            ovf_flags  <= '0;
        end else begin
            urun_flags <= (urun_flags & ~(clr_wr ? wr_data[NUM_LANES-1:0] : '0)) | urun_evt;
            ovf_flags  <= (ovf_flags & ~(clr_wr ? wr_data[8 +: NUM_LANES] : '0)) | ovf_evt;
        end
    end

    always_comb begin
        all_low = 1'b1;
        for (int i = 0; i < NUM_LANES; i++)
            if (mask_eff[i] && (fifo_lvl[i] > wm_q)) all_low = 1'b0;
    end

    assign fifo_req = tx_en && all_low;
endmodule

// File: rtl/txl_bank_chk.sv
module txl_bank_chk
    import txl_pkg::*;
#(
    parameter int NUM_LANES = 8,
    parameter int DEPTH     = 16,
    parameter int DATA_W    = 32,
    parameter int LVL_W     = 5
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        tx_en,
    input logic                        slot_stb,
    input logic                        wr_en,
    input logic [ADDR_W-1:0]           wr_addr,
    input logic [DATA_W-1:0]           wr_data,
    input logic [MAX_LANES-1:0]        lane_mask,
    input logic [NUM_LANES*DATA_W-1:0] lane_word,
    input logic [NUM_LANES*LVL_W-1:0]  lane_level,
    input logic [NUM_LANES-1:0]        urun_flags,
    input logic [NUM_LANES-1:0]        ovf_flags,
    input logic                        fifo_req
);
    logic clr_wr;
    assign clr_wr = wr_en && (wr_addr == ADDR_FLAGCLR);

    assert_mask_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        tx_en |=> $stable(lane_mask));

    assert_flush_empty_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_en) |=> (lane_level == '0));

    assert_req_needs_tx_R9: assert property (@(posedge clk) disable iff (rst)
        fifo_req |-> tx_en);

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_chk
        assert_urun_sticky_R5: assert property (@(posedge clk) disable iff (rst)
            (urun_flags[i] && !(clr_wr && wr_data[i])) |=> urun_flags[i]);

        assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
            (ovf_flags[i] && !(clr_wr && wr_data[8+i])) |=> ovf_flags[i]);

        assert_disabled_no_urun_R4: assert property (@(posedge clk) disable iff (rst)
            (!urun_flags[i] && !(slot_stb && tx_en && lane_mask[i])) |=> !urun_flags[i]);

        assert_urun_zero_R4: assert property (@(posedge clk) disable iff (rst)
            (slot_stb && tx_en && lane_mask[i] && (lane_level[i*LVL_W +: LVL_W] == '0))
            |=> ((lane_word[i*DATA_W +: DATA_W] == '0) && urun_flags[i]));

        assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
            lane_level[i*LVL_W +: LVL_W] <= LVL_W'(DEPTH));
    end
endmodule

bind txl_bank txl_bank_chk #(
    .NUM_LANES(NUM_LANES),
    .DEPTH    (DEPTH),
    .DATA_W   (DATA_W),
    .LVL_W    (LVL_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tx_en     (tx_en),
    .slot_stb  (slot_stb),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .lane_mask (mask_eff),
    .lane_word (lane_word),
    .lane_level(lane_level),
    .urun_flags(urun_flags),
    .ovf_flags (ovf_flags),
    .fifo_req  (fifo_req)
);

// File: tb/txl_bank_tb.sv
module txl_bank_tb;
    localparam int LANES = 8;
    localparam int DEPTH = 16;
    localparam int DW    = 32;
    localparam int LW    = $clog2(DEPTH + 1);

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                tx_en = 1'b0;
    logic                slot_stb = 1'b0;
    logic                wr_en = 1'b0;
    logic [5:0]          wr_addr = '0;
    logic [DW-1:0]       wr_data = '0;
    logic [LANES*DW-1:0] lane_word;
    logic [LANES*LW-1:0] lane_level;
    logic [LANES-1:0]    urun_flags, ovf_flags;
    logic                fifo_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // scoreboard model
    logic [DW-1:0]       mq [0:LANES-1][$];
    logic [LANES*DW-1:0] slot_q [$];
    logic [7:0]          m_mask = 8'h01;
    bit                  m_comb = 1'b0;
    int                  m_wm   = 0;
    int                  m_ptr  = 0;
    logic [7:0]          m_urun = '0;
    logic [7:0]          m_ovf  = '0;

    always #10 clk = ~clk;

    txl_bank #(.NUM_LANES(LANES), .DEPTH(DEPTH), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .tx_en(tx_en), .slot_stb(slot_stb),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .lane_word(lane_word), .lane_level(lane_level),
        .urun_flags(urun_flags), .ovf_flags(ovf_flags), .fifo_req(fifo_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_put(input int ln, input logic [DW-1:0] d);
        if (mq[ln].size() < DEPTH) mq[ln].push_back(d);
        else m_ovf[ln] = 1'b1;
    endtask

    // driver: predicts effect from the requirements, then drives one write
    task automatic bus_wr(input logic [5:0] a, input logic [DW-1:0] d);
        if (a == 6'h00) begin
            m_wm = int'(d[16 +: LW]);
            if (!tx_en) begin
                m_mask = d[7:0];
                m_comb = (d[9:8] == 2'd2);
            end
        end else if (a == 6'h01) begin
            m_urun &= ~d[7:0];
            m_ovf  &= ~d[15:8];
        end else if (a == 6'h02) begin
            if (m_comb) begin
                for (int s = 0; s < LANES; s++) begin
                    int ln;
                    ln = (m_ptr + s) % LANES;
                    if (m_mask[ln]) begin
                        model_put(ln, d);
                        m_ptr = (ln + 1) % LANES;
                        break;
                    end
                end
            end
        end else if (a[5:3] == 3'b001) begin
            if (!m_comb) model_put(int'(a[2:0]), d);
        end
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_tx(input bit v);
        if (tx_en && !v) begin
            for (int l = 0; l < LANES; l++) mq[l].delete();
            m_ptr = 0;
        end
        tx_en = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic strobe();
        logic [LANES*DW-1:0] e;
        e = '0;
        for (int l = 0; l < LANES; l++) begin
            if (tx_en && m_mask[l]) begin
                if (mq[l].size() == 0) m_urun[l] = 1'b1;
                else e[l*DW +: DW] = mq[l].pop_front();
            end
        end
        if (tx_en) slot_q.push_back(e);
        slot_stb = 1'b1;
        @(negedge clk);
        slot_stb = 1'b0;
    endtask

    task automatic check_state(input string tag);
        bit req;
        req = tx_en;
        for (int l = 0; l < LANES; l++) begin
            chk({tag, " level"}, 32'(lane_level[l*LW +: LW]), 32'(mq[l].size()));
            if (m_mask[l] && mq[l].size() > m_wm) req = 1'b0;
        end
        chk({tag, " underrun flags"}, 32'(urun_flags), 32'(m_urun));
        chk({tag, " overflow flags"}, 32'(ovf_flags), 32'(m_ovf));
        chk({tag, " R9 request"}, 32'(fifo_req), 32'(req));
    endtask

    // monitor: compares each strobe's output words against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            if (slot_stb && tx_en) begin
                logic [LANES*DW-1:0] e;
                @(negedge clk);
                e = slot_q.pop_front();
                for (int l = 0; l < LANES; l++)
                    chk("R3 slot word", lane_word[l*DW +: DW], e[l*DW +: DW]);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 words", 32'(lane_word != '0), 32'd0);
        check_state("R1");

        // R2/R3/R1: per-line writes, default mask pops only line 0
        bus_wr(6'h08, 32'hA000_0001);
        bus_wr(6'h09, 32'hB000_0001);
        bus_wr(6'h08, 32'hA000_0002);
        check_state("R2");
        set_tx(1'b1);
        strobe();
        check_state("R1 R3 default mask");
        strobe();
        check_state("R2 order");
        // R4: line 0 now empty, line 1 disabled
        strobe();
        check_state("R4 underrun");
        // R5: zero write leaves flag, one write clears it
        bus_wr(6'h01, 32'h0000_0000);
        check_state("R5 no clear");
        bus_wr(6'h01, 32'h0000_0001);
        check_state("R5 clear");

        // R11: falling enable empties line 1
        set_tx(1'b0);
        check_state("R11 flush");

        // R7 fields, non-contiguous mask 0xA5, watermark 1
        bus_wr(6'h00, 32'h0001_00A5);
        bus_wr(6'h0A, 32'hC200_0001);
        bus_wr(6'h0A, 32'hC200_0002);
        bus_wr(6'h0D, 32'hC500_0001);
        bus_wr(6'h08, 32'hC000_0001);
        bus_wr(6'h0F, 32'hC700_0001);
        set_tx(1'b1);
        check_state("R9 above watermark");
        strobe();
        check_state("R9 R3 sparse mask");
        // R10: mask write while running is ignored
        bus_wr(6'h00, 32'h0001_00FF);
        strobe();
        check_state("R10 R4 mask frozen");
        bus_wr(6'h01, 32'h0000_FFFF);
        check_state("R5 clear all");

        // R6: overflow on line 5
        set_tx(1'b0);
        for (int k = 0; k <= DEPTH; k++) bus_wr(6'h0D, 32'hD500_0000 + 32'(k));
        check_state("R6 overflow");
        set_tx(1'b1);
        strobe();
        check_state("R6 order after drop");
        bus_wr(6'h01, 32'h0000_FFFF);
        check_state("R5 clear overflow");

        // R7/R8: combined mode over lines 1,2,5
        set_tx(1'b0);
        bus_wr(6'h00, 32'h0000_0226);
        for (int k = 0; k < 5; k++) bus_wr(6'h02, 32'hE000_0000 + 32'(k));
        bus_wr(6'h0D, 32'hDEAD_0005);
        check_state("R7 R8 combined steering");
        set_tx(1'b1);
        strobe();
        strobe();
        check_state("R7 combined drain");
        bus_wr(6'h01, 32'h0000_FFFF);

        // R11: write position back to the lowest line after disable
        bus_wr(6'h02, 32'hF000_0001);
        set_tx(1'b0);
        bus_wr(6'h02, 32'hF000_0002);
        check_state("R11 pointer reset");

        // R8: common address ignored in per-line mode
        set_tx(1'b1);
        set_tx(1'b0);
        bus_wr(6'h00, 32'h0000_0001);
        bus_wr(6'h02, 32'hF000_0003);
        check_state("R8 common ignored");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule